// File: doc/BRIEF.md
# Bus Address Map Translator

This block relocates addresses from an 18-bit peripheral bus into a 22-bit physical memory space. The bus space is cut into 32 windows of 8 KB. Each window has a map entry that holds a 22-bit physical base. A bus access whose address falls in window `k` comes out at entry `k`'s base plus the 13-bit offset inside the window. An external control bit, `map_en_i`, turns relocation on. While that bit is clear, every bus address passes through unchanged, zero-extended to 22 bits.

Software reaches the entries through a register port of 64 16-bit words. The words sit at byte addresses 170200 to 170376 octal. The register port takes the word address, which is the byte address shifted right by one. Entry `k` uses two words: the word at slot `2k` holds the low part of the base and the word at slot `2k+1` holds the high part. The read path is combinational. A write lands on the next rising clock edge. The translation path is combinational from the bus address, the enable bit and the selected entry.

Top module: `bus_map_xlate`

## Requirements
- R1: After reset every map word reads as zero.
- R2: A low word (even slot) stores bits 15:1. Its bit 0 always reads 0. Writing 0xFFFF reads back 0xFFFE (177776 octal).
- R3: A high word (odd slot) stores bits 5:0. Its bits 15:6 always read 0. Writing 0xFFFF reads back 0x003F (000077 octal).
- R4: `reg_hit_o` is 1 exactly when the word address `reg_addr_i` lies in 074100 to 074177 octal (byte address 170200 to 170376). The slot is `reg_addr_i - 074100` octal. Slot `2k` is the low word of entry `k` and slot `2k+1` is the high word.
- R5: When `reg_hit_o` is 0, a write changes no map word and `reg_rdata_o` is 0.
- R6: With `map_en_i` = 0, `phys_addr_o` equals `bus_addr_i` zero-extended to 22 bits.
- R7: With `map_en_i` = 1, `bus_addr_i[17:13]` selects entry `k`. The output is `phys_addr_o = ({high[5:0], low[15:1], 0} + bus_addr_i[12:0]) mod 2^22`.
- R8: Reads and writes of map words behave the same whatever the value of `map_en_i`.
- R9: A write shows on `reg_rdata_o` and on `phys_addr_o` in the cycle after the clock edge that takes it. Before that edge, reads return the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| map_en_i | input | 1 | Relocation enable, from an external control register |
| reg_we_i | input | 1 | Write strobe for the map word port |
| reg_addr_i | input | 17 | Word address (byte address bits 17:1) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational, zero on a miss |
| reg_hit_o | output | 1 | Address falls in the map word window |
| bus_addr_i | input | 18 | Bus address to translate |
| phys_addr_o | output | 22 | Translated physical address |

## Verification
The assertions check four things on every cycle: the masks on the low and high words, zero read data outside the window, pass-through while relocation is off, and that bit 0 of the address is kept while relocation is on. They also check that a write reads back masked on the next cycle when the address is held. Other behaviours need the bench's scenarios and its cycle-level reference model. These are the window limits, the slot-to-entry pairing, the base-plus-offset sum including the wrap past 2^22, misses leaving stored words intact, and access while relocation is enabled.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned BUS_AW  = 18;
  localparam int unsigned PHYS_AW = 22;
  localparam int unsigned N_ENT   = 32;
  // byte address of slot 0
  localparam logic [BUS_AW-1:0] WIN_BASE = 18'o170200;
endpackage

// File: rtl/bmx_decode.sv
module bmx_decode #(
  parameter int unsigned BUS_AW = 18,
  parameter int unsigned N_ENT  = 32,
  parameter logic [BUS_AW-1:0] WIN_BASE = 18'o170200,
  localparam int unsigned SLOT_W = $clog2(2*N_ENT)
) (
  input  logic [BUS_AW-2:0] addr_i,
  output logic              hit_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [BUS_AW-2:0] WBASE = WIN_BASE[BUS_AW-1:1];

  assign hit_o  = (addr_i[BUS_AW-2:SLOT_W] == WBASE[BUS_AW-2:SLOT_W]);
  assign slot_o = addr_i[SLOT_W-1:0];
endmodule

// File: rtl/bmx_regfile.sv
module bmx_regfile #(
  parameter int unsigned N_ENT   = 32,
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned PHYS_AW = 22,
  localparam int unsigned SLOT_W = $clog2(2*N_ENT),
  localparam int unsigned ENT_W  = $clog2(N_ENT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [WORD_W-1:0]  rdata_o,
  input  logic [ENT_W-1:0]   ent_i,
  output logic [PHYS_AW-1:0] base_o
);
  localparam int unsigned HI_W = PHYS_AW - WORD_W;
  localparam logic [WORD_W-1:0] LO_MASK = {{(WORD_W-1){1'b1}}, 1'b0};
  localparam logic [WORD_W-1:0] HI_MASK = WORD_W'((1 << HI_W) - 1);

  logic [WORD_W-1:0] lo_q [N_ENT];
  logic [WORD_W-1:0] hi_q [N_ENT];

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic sel;
    assign sel = we_i && (slot_i[SLOT_W-1:1] == ENT_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q[e] <= '0;
        hi_q[e] <= '0;
      end else if (sel) begin
        if (slot_i[0]) hi_q[e] <= wdata_i & HI_MASK;
        else           lo_q[e] <= wdata_i & LO_MASK;
      end
    end
  end

  always_comb begin
    if (slot_i[0]) rdata_o = hi_q[slot_i[SLOT_W-1:1]];
    else           rdata_o = lo_q[slot_i[SLOT_W-1:1]];
  end

  // lo bit 0 is held at zero, so the concatenation is the byte base
  assign base_o = PHYS_AW'({hi_q[ent_i], lo_q[ent_i]});
endmodule

// File: rtl/bmx_xlate.sv
module bmx_xlate #(
  parameter int unsigned BUS_AW  = 18,
  parameter int unsigned PHYS_AW = 22,
  parameter int unsigned N_ENT   = 32,
  localparam int unsigned OFS_W  = BUS_AW - $clog2(N_ENT)
) (
  input  logic               en_i,
  input  logic [BUS_AW-1:0]  bus_i,
  input  logic [PHYS_AW-1:0] base_i,
  output logic [PHYS_AW-1:0] phys_o
);
  logic [PHYS_AW-1:0] reloc;
  assign reloc  = base_i + PHYS_AW'(bus_i[OFS_W-1:0]);
  assign phys_o = en_i ? reloc : PHYS_AW'(bus_i);
endmodule

// File: rtl/bus_map_xlate.sv
module bus_map_xlate
  import bmx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               map_en_i,
  input  logic               reg_we_i,
  input  logic [BUS_AW-2:0]  reg_addr_i,
  input  logic [WORD_W-1:0]  reg_wdata_i,
  output logic [WORD_W-1:0]  reg_rdata_o,
  output logic               reg_hit_o,
  input  logic [BUS_AW-1:0]  bus_addr_i,
  output logic [PHYS_AW-1:0] phys_addr_o
);
  localparam int unsigned SLOT_W = $clog2(2*N_ENT);
  localparam int unsigned ENT_W  = $clog2(N_ENT);

  logic              hit;
  logic [SLOT_W-1:0] slot;
  logic [WORD_W-1:0] rf_rdata;
  logic [PHYS_AW-1:0] base;

  bmx_decode #(.BUS_AW(BUS_AW), .N_ENT(N_ENT), .WIN_BASE(WIN_BASE)) u_dec (
    .addr_i(reg_addr_i), .hit_o(hit), .slot_o(slot)
  );

  bmx_regfile #(.N_ENT(N_ENT), .WORD_W(WORD_W), .PHYS_AW(PHYS_AW)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i && hit),
    .slot_i  (slot),
    .wdata_i (reg_wdata_i),
    .rdata_o (rf_rdata),
    .ent_i   (bus_addr_i[BUS_AW-1 -: ENT_W]),
    .base_o  (base)
  );

  bmx_xlate #(.BUS_AW(BUS_AW), .PHYS_AW(PHYS_AW), .N_ENT(N_ENT)) u_xl (
    .en_i(map_en_i), .bus_i(bus_addr_i), .base_i(base), .phys_o(phys_addr_o)
  );

  assign reg_hit_o   = hit;
  assign reg_rdata_o = hit ? rf_rdata : '0;
endmodule

// File: rtl/bmx_chk.sv
module bmx_chk
  import bmx_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               map_en_i,
  input logic               reg_we_i,
  input logic [BUS_AW-2:0]  reg_addr_i,
  input logic [WORD_W-1:0]  reg_wdata_i,
  input logic [WORD_W-1:0]  reg_rdata_o,
  input logic               reg_hit_o,
  input logic [BUS_AW-1:0]  bus_addr_i,
  input logic [PHYS_AW-1:0] phys_addr_o
);
  localparam int unsigned HI_W = PHYS_AW - WORD_W;
  localparam logic [WORD_W-1:0] HI_M = WORD_W'((1 << HI_W) - 1);
  localparam logic [WORD_W-1:0] LO_M = {{(WORD_W-1){1'b1}}, 1'b0};

  AST_LO_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_hit_o && !reg_addr_i[0]) |-> (reg_rdata_o[0] == 1'b0)); // R2
  AST_HI_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_hit_o && reg_addr_i[0]) |-> ((reg_rdata_o & ~HI_M) == '0)); // R3
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_hit_o |-> (reg_rdata_o == '0)); // R5
  AST_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !map_en_i |-> (phys_addr_o == PHYS_AW'(bus_addr_i))); // R6
  AST_RELOC_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_en_i |-> (phys_addr_o[0] == bus_addr_i[0])); // R7
  AST_WRITE_VIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_hit_o) |=> ($stable(reg_addr_i) ->
      (reg_rdata_o == ($past(reg_wdata_i) & (reg_addr_i[0] ? HI_M : LO_M))))); // R9
endmodule

bind bus_map_xlate bmx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .map_en_i(map_en_i), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .reg_hit_o(reg_hit_o), .bus_addr_i(bus_addr_i), .phys_addr_o(phys_addr_o)
);

// File: tb/sim_bus_map_xlate.sv
`timescale 1ns/1ps
module sim_bus_map_xlate;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        map_en = 0;
  logic        we = 0;
  logic [16:0] waddr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        hit;
  logic [17:0] bus = '0;
  logic [21:0] phys;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  int lo_m [32];
  int hi_m [32];
  localparam int WBASE = 'o74100;

  always #2.5 clk = ~clk;

  bus_map_xlate u0 (
    .clk_i(clk), .rst_ni(rst_n), .map_en_i(map_en), .reg_we_i(we),
    .reg_addr_i(waddr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .reg_hit_o(hit), .bus_addr_i(bus), .phys_addr_o(phys)
  );

  function automatic int ref_hit(int a);
    return (a >= WBASE && a < WBASE + 64) ? 1 : 0;
  endfunction

  function automatic int ref_rd(int a);
    int s;
    if (!ref_hit(a)) return 0;
    s = a - WBASE;
    return (s % 2) ? hi_m[s/2] : lo_m[s/2];
  endfunction

  function automatic int ref_phys(int en, int b);
    int e;
    if (!en) return b;
    e = b / 8192;
    return ((hi_m[e] * 65536 + lo_m[e]) + (b % 8192)) % (1 << 22);
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0o expected %0o", req, what, got, exp);
    end
  endtask

  // drive at negedge, compare combinational outputs, then let the edge update the model
  task automatic step(string req, int w, int a, int d, int en, int b);
    int s;
    @(negedge clk);
    we = w[0]; waddr = a[16:0]; wdata = d[15:0]; map_en = en[0]; bus = b[17:0];
    #1;
    chk(req, "rdata", int'(rdata), ref_rd(a));
    chk(req, "hit",   int'(hit),   ref_hit(a));
    chk(req, "phys",  int'(phys),  ref_phys(en, b));
    @(posedge clk);
    if (w != 0 && ref_hit(a)) begin
      s = a - WBASE;
      if (s % 2) hi_m[s/2] = d & 'o77;
      else       lo_m[s/2] = d & 'o177776;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin lo_m[i] = 0; hi_m[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 64; i++) step("R1", 0, WBASE + i, 0, 0, i * 4099);
    // R2 / R3 masks
    step("R2", 1, WBASE, 'hFFFF, 0, 0);
    step("R2", 0, WBASE, 0, 0, 0);
    step("R3", 1, WBASE + 1, 'hFFFF, 0, 0);
    step("R3", 0, WBASE + 1, 0, 0, 0);
    // R4 / R8 fill with relocation off, read back with it on
    for (int i = 0; i < 32; i++) begin
      step("R4", 1, WBASE + 2*i, (i * 'o100) | 1, 0, 0);
      step("R4", 1, WBASE + 2*i + 1, i | 'o1700, 0, 0);
    end
    for (int i = 0; i < 64; i++) step("R8", 0, WBASE + i, 0, 1, i * 4096);
    // R4 window edges, R5 misses leave words intact
    step("R5", 1, WBASE - 1, 'hFFFF, 0, 0);
    step("R5", 1, WBASE + 64, 'hFFFF, 0, 0);
    step("R5", 1, 'o74000, 'hFFFF, 0, 0);
    step("R5", 0, WBASE + 63, 0, 0, 0);
    step("R5", 0, WBASE, 0, 0, 0);
    // R6 pass-through
    step("R6", 0, 0, 0, 0, 'o777777);
    step("R6", 0, 0, 0, 0, 'o020200);
    step("R6", 0, 0, 0, 0, 'o400001);
    // R7 relocation example: entry 1 base 004000
    step("R7", 1, WBASE + 2, 'o004000, 1, 0);
    step("R7", 1, WBASE + 3, 0, 1, 0);
    step("R7", 0, 0, 0, 1, 'o020000);
    step("R7", 0, 0, 0, 1, 'o020200);
    // R7 wrap: entry 31 at top of physical space
    step("R7", 1, WBASE + 62, 'hFFFF, 1, 0);
    step("R7", 1, WBASE + 63, 'hFFFF, 1, 0);
    step("R7", 0, 0, 0, 1, 'o777777);
    // R9 write then same-cycle and next-cycle views
    step("R9", 1, WBASE + 2, 'o123456, 1, 'o020017);
    step("R9", 0, WBASE + 2, 0, 1, 'o020017);
    // mixed traffic, R7 and R8 together
    for (int i = 0; i < 400; i++) begin
      int a;
      a = WBASE - 4 + $urandom_range(0, 71);
      step("R7", int'($urandom_range(0, 1)), a, int'($urandom_range(0, 65535)),
           int'($urandom_range(0, 1)), int'($urandom_range(0, 262143)));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule